// File: doc/BRIEF.md
# Delayed-Branch Control Transfer Unit

This block steers the program counter for control transfers that carry a single delay slot. Three transfer kinds are handled: an unconditional PC-relative branch, a PC-relative call that records its own address in a fixed link register, and a register-indirect jump that links into a chosen destination register. The surrounding pipeline presents one retiring instruction per `adv_i` cycle, with its address on `pc_i` and, for a transfer, its decoded kind, displacement field and operands.

When a transfer retires, the unit writes the link register at once, reports the sequential address as the next PC and arms a pending redirect. The instruction after the transfer is always executed as the delay slot. If that slot instruction retires cleanly, the stored target is loaded into the next PC and `taken_o` pulses. If the slot raises an exception, the redirect is dropped. The delay state passes through a one-cycle fault value and then returns to idle. A transfer request that arrives while a redirect is pending, or during the fault cycle, is flagged and discarded.

Top module: `xfer_ctl_unit`

## Requirements
- R1: After reset, `next_pc_o` equals the `RESET_PC` parameter (0 by default), `dly_state_o` is 2'b00, and `link_we_o`, `taken_o` and `overlap_err_o` are low.
- R2: An `adv_i` cycle with `kind_i` = 2'b00 (no transfer) in the idle state sets `next_pc_o` to `pc_i` + 4 at the next clock, modulo 2^32.
- R3: A call (`kind_i` = 2'b10) writes `pc_i` to register 15. Its target is `pc_i` plus the 30-bit `field_i`, shifted left by two and sign-extended.
- R4: A branch (`kind_i` = 2'b01) targets `pc_i` plus bits [21:0] of `field_i`, shifted left by two and sign-extended. The upper field bits are ignored, and a branch performs no link write.
- R5: A jump-and-link (`kind_i` = 2'b11) targets `rs1_val_i` + `rs2_val_i` when `use_imm_i` is 0. When `use_imm_i` is 1 it targets `rs1_val_i` plus bits [12:0] of `field_i`, sign-extended. In both cases it writes `pc_i` to register `rd_i`.
- R6: A jump-and-link with `rd_i` = 0 makes no link write, but the jump still takes effect.
- R7: `dly_state_o` uses 2'b00 for not-delayed, 2'b01 for to-be-delayed and 2'b10 for exception-in-slot.
  - One clock after a transfer is accepted, `next_pc_o` = `pc_i` + 4, `dly_state_o` = 2'b01 and `link_we_o` pulses for one cycle.
  - One clock after the next `adv_i` without `slot_exc_i`, `next_pc_o` = target, `taken_o` pulses for one cycle and `dly_state_o` = 2'b00.
- R8: A delay-slot retirement with `slot_exc_i` high drops the redirect. One clock later `dly_state_o` = 2'b10, `next_pc_o` = slot `pc_i` + 4 and `taken_o` is low. The clock after that, `dly_state_o` = 2'b00.
- R9: A transfer request while `dly_state_o` is not 2'b00 pulses `overlap_err_o` and is ignored. It causes no link write, and the pending target is unchanged.
- R10: Without `adv_i`, `next_pc_o` holds, a pending redirect stays armed, and no pulse output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | An instruction retires this cycle |
| kind_i | input | 2 | Transfer kind of the retiring instruction |
| field_i | input | 30 | Displacement / immediate field |
| rs1_val_i | input | 32 | First source register value (jump) |
| rs2_val_i | input | 32 | Second source register value (jump) |
| use_imm_i | input | 1 | Jump uses immediate instead of rs2 |
| rd_i | input | 5 | Jump link destination register |
| slot_exc_i | input | 1 | Retiring instruction raised an exception |
| pc_i | input | 32 | Address of the retiring instruction |
| next_pc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Link value (transfer's own address) |
| dly_state_o | output | 2 | Delay-slot state |
| taken_o | output | 1 | PC redirected this cycle |
| overlap_err_o | output | 1 | Transfer request rejected |

## Verification
Every result is registered, so each output reflects a retirement exactly one clock after the edge that samples it. The link write and the armed state appear one clock after the transfer retires. The redirect and `taken_o` appear one clock after the delay slot retires. The fault state needs one more clock to clear. The bench drives inputs on the falling edge and compares outputs on the following falling edge, a full cycle later. Transfers are swept over several PC values and a set of displacement and immediate fields that includes the extreme positive and negative encodings, with targets recomputed arithmetically in the bench.

// File: rtl/xfer_ctl_pkg.sv
// Package: shared encodings for the delayed-branch transfer unit.
// Assumes 2-bit codes are fixed by the decoder feeding the unit.
package xfer_ctl_pkg;

    typedef enum logic [1:0] {
        XK_NONE   = 2'b00,
        XK_BRANCH = 2'b01,
        XK_CALL   = 2'b10,
        XK_JMPL   = 2'b11
    } xfer_kind_t;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'b00,
        DS_ARMED = 2'b01,
        DS_FAULT = 2'b10
    } dslot_t;

endpackage

// File: rtl/xfer_target_calc.sv
// Module: xfer_target_calc
// Computes the redirect address for each transfer kind (combinational).
// Assumes the field is right-aligned and FIELD_W+2 <= AW.
module xfer_target_calc
    import xfer_ctl_pkg::*;
#(
    parameter int AW      = 32,
    parameter int FIELD_W = 30,
    parameter int BR_W    = 22,
    parameter int IMM_W   = 13
) (
    input  xfer_kind_t         kind_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [AW-1:0]      pc_i,
    input  logic [AW-1:0]      rs1_i,
    input  logic [AW-1:0]      rs2_i,
    input  logic               use_imm_i,
    output logic [AW-1:0]      target_o
);

    logic [AW-1:0] call_off;
    logic [AW-1:0] br_off;
    logic [AW-1:0] imm_ext;

    // Sign-extend the word displacements and the immediate to address width.
    always_comb begin
        call_off = AW'($signed({field_i, 2'b00}));
        br_off   = AW'($signed({field_i[BR_W-1:0], 2'b00}));
        imm_ext  = AW'($signed(field_i[IMM_W-1:0]));
    end

    // Select the target by transfer kind.
    always_comb begin
        unique case (kind_i)
            XK_CALL:   target_o = pc_i + call_off;
            XK_BRANCH: target_o = pc_i + br_off;
            XK_JMPL:   target_o = rs1_i + (use_imm_i ? imm_ext : rs2_i);
            default:   target_o = pc_i;
        endcase
    end

endmodule

// File: rtl/xfer_link_gen.sv
// Module: xfer_link_gen
// Produces the one-cycle link-register write for an accepted transfer.
// Assumes accept_i is high only for a transfer taken in the idle state.
module xfer_link_gen
    import xfer_ctl_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RIDX_W   = 5,
    parameter int CALL_REG = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  xfer_kind_t        kind_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [AW-1:0]     pc_i,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [AW-1:0]     link_data_o
);

    localparam logic [RIDX_W-1:0] CALL_IDX = RIDX_W'(CALL_REG);
    localparam logic [RIDX_W-1:0] ZERO_IDX = '0;

    logic [RIDX_W-1:0] dest;
    logic              wants_link;

    // Pick the destination register and decide whether a write is needed.
    always_comb begin
        dest       = (kind_i == XK_CALL) ? CALL_IDX : rd_i;
        wants_link = ((kind_i == XK_CALL) || (kind_i == XK_JMPL)) && (dest != ZERO_IDX);
    end

    // Register the write strobe, index and the transfer's own address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_we_o   <= 1'b0;
            link_idx_o  <= '0;
            link_data_o <= '0;
        end else begin
            link_we_o <= accept_i && wants_link;
            if (accept_i && wants_link) begin
                link_idx_o  <= dest;
                link_data_o <= pc_i;
            end
        end
    end

    // A link write never targets the hardwired zero register (R6).
    p_no_zero_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != ZERO_IDX));

endmodule

// File: rtl/xfer_slot_seq.sv
// Module: xfer_slot_seq
// Delay-slot sequencer: arms a redirect, commits it after a clean slot,
// drops it on a slot exception, and rejects overlapping requests.
// Assumes one retirement per adv_i cycle, in program order.
module xfer_slot_seq
    import xfer_ctl_pkg::*;
#(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   RESET_PC = '0,
    parameter int              INSN_B   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  xfer_kind_t    kind_i,
    input  logic          slot_exc_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] target_i,
    output logic          accept_o,
    output logic [AW-1:0] next_pc_o,
    output dslot_t        state_o,
    output logic          taken_o,
    output logic          overlap_err_o
);

    localparam logic [AW-1:0] STEP = AW'(INSN_B);

    logic [AW-1:0] target_q;
    logic          has_req;
    logic [AW-1:0] seq_pc;

    // Decode acceptance of a new transfer and the fall-through address.
    always_comb begin
        has_req  = (kind_i != XK_NONE);
        accept_o = adv_i && has_req && (state_o == DS_IDLE);
        seq_pc   = pc_i + STEP;
    end

    // Advance the delay state, the next PC and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o       <= DS_IDLE;
            next_pc_o     <= RESET_PC;
            target_q      <= '0;
            taken_o       <= 1'b0;
            overlap_err_o <= 1'b0;
        end else begin
            taken_o       <= 1'b0;
            overlap_err_o <= 1'b0;
            if (state_o == DS_FAULT) begin
                state_o <= DS_IDLE;
            end
            if (adv_i) begin
                unique case (state_o)
                    DS_IDLE: begin
                        next_pc_o <= seq_pc;
                        if (has_req) begin
                            state_o  <= DS_ARMED;
                            target_q <= target_i;
                        end
                    end
                    DS_ARMED: begin
                        overlap_err_o <= has_req;
                        if (slot_exc_i) begin
                            state_o   <= DS_FAULT;
                            next_pc_o <= seq_pc;
                        end else begin
                            state_o   <= DS_IDLE;
                            next_pc_o <= target_q;
                            taken_o   <= 1'b1;
                        end
                    end
                    default: begin
                        next_pc_o     <= seq_pc;
                        overlap_err_o <= has_req;
                    end
                endcase
            end
        end
    end

    // The new PC is loaded only with the delay state back at idle (R7).
    p_redirect_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (state_o == DS_IDLE));

    // The fault state lasts exactly one cycle (R8).
    p_fault_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == DS_FAULT) |=> (state_o == DS_IDLE));

    // Without a retirement the next PC holds and no redirect pulses (R10).
    p_hold_no_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && state_o != DS_FAULT) |=> ($stable(next_pc_o) && !taken_o && $stable(state_o)));

    // The state never takes the unused encoding (R7).
    p_state_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != dslot_t'(2'b11));

endmodule

// File: rtl/xfer_ctl_unit.sv
// Module: xfer_ctl_unit (top)
// PC control for delay-slot transfers: branch, call with fixed link
// register, and register-indirect jump-and-link.
// Assumes the decoder supplies kind, field and operands with each retirement.
module xfer_ctl_unit
    import xfer_ctl_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            FIELD_W  = 30,
    parameter int            BR_W     = 22,
    parameter int            IMM_W    = 13,
    parameter int            RIDX_W   = 5,
    parameter int            CALL_REG = 15,
    parameter logic [31:0]   RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [1:0]        kind_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [AW-1:0]     rs1_val_i,
    input  logic [AW-1:0]     rs2_val_i,
    input  logic              use_imm_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic              slot_exc_i,
    input  logic [AW-1:0]     pc_i,
    output logic [AW-1:0]     next_pc_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [AW-1:0]     link_data_o,
    output logic [1:0]        dly_state_o,
    output logic              taken_o,
    output logic              overlap_err_o
);

    xfer_kind_t    kind;
    logic [AW-1:0] target;
    logic          accept;
    dslot_t        state;

    // Map the raw kind code onto the shared enum.
    always_comb begin
        kind        = xfer_kind_t'(kind_i);
        dly_state_o = state;
    end

    xfer_target_calc #(
        .AW(AW), .FIELD_W(FIELD_W), .BR_W(BR_W), .IMM_W(IMM_W)
    ) u_target (
        .kind_i(kind), .field_i(field_i), .pc_i(pc_i),
        .rs1_i(rs1_val_i), .rs2_i(rs2_val_i), .use_imm_i(use_imm_i),
        .target_o(target)
    );

    xfer_slot_seq #(
        .AW(AW), .RESET_PC(AW'(RESET_PC)), .INSN_B(4)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .kind_i(kind),
        .slot_exc_i(slot_exc_i), .pc_i(pc_i), .target_i(target),
        .accept_o(accept), .next_pc_o(next_pc_o), .state_o(state),
        .taken_o(taken_o), .overlap_err_o(overlap_err_o)
    );

    xfer_link_gen #(
        .AW(AW), .RIDX_W(RIDX_W), .CALL_REG(CALL_REG)
    ) u_link (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .kind_i(kind),
        .rd_i(rd_i), .pc_i(pc_i), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_data_o(link_data_o)
    );

    // A link write coincides with the armed delay state (R7).
    p_link_arms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (state == DS_ARMED));

    // A rejected request never produces a link write (R9).
    p_reject_no_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err_o |-> !link_we_o);

    // Link write and redirect never fall in the same cycle (R3).
    p_link_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_we_o && taken_o));

endmodule

// File: tb/xfer_ctl_unit_bench.sv
module xfer_ctl_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_i;
    logic [1:0]  kind_i;
    logic [29:0] field_i;
    logic [31:0] rs1_val_i, rs2_val_i, pc_i;
    logic        use_imm_i, slot_exc_i;
    logic [4:0]  rd_i;
    logic [31:0] next_pc_o, link_data_o;
    logic        link_we_o, taken_o, overlap_err_o;
    logic [4:0]  link_idx_o;
    logic [1:0]  dly_state_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    xfer_ctl_unit u_xfer_ctl_unit (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .kind_i(kind_i),
        .field_i(field_i), .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i),
        .use_imm_i(use_imm_i), .rd_i(rd_i), .slot_exc_i(slot_exc_i),
        .pc_i(pc_i), .next_pc_o(next_pc_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_data_o(link_data_o),
        .dly_state_o(dly_state_o), .taken_o(taken_o),
        .overlap_err_o(overlap_err_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Signed value of the low w bits of v.
    function automatic longint sx(logic [31:0] v, int w);
        longint r = longint'(v) & ((longint'(1) << w) - 1);
        if (r >= (longint'(1) << (w - 1))) r = r - (longint'(1) << w);
        return r;
    endfunction

    // Drive one cycle of inputs on the falling edge; return one cycle later.
    task automatic cyc(logic adv, logic [1:0] k, logic [29:0] f, logic [31:0] a,
                       logic [31:0] b, logic imm, logic [4:0] rd, logic exc,
                       logic [31:0] pc);
        adv_i = adv; kind_i = k; field_i = f; rs1_val_i = a; rs2_val_i = b;
        use_imm_i = imm; rd_i = rd; slot_exc_i = exc; pc_i = pc;
        @(negedge clk);
    endtask

    // Full transfer: accept at pc, then clean delay slot at pc+4.
    task automatic xfer(string tag, logic [1:0] k, logic [29:0] f, logic [31:0] a,
                        logic [31:0] b, logic imm, logic [4:0] rd,
                        logic [31:0] pc, logic [31:0] tgt, logic we,
                        logic [4:0] idx);
        cyc(1'b1, k, f, a, b, imm, rd, 1'b0, pc);
        chk({tag, " R7 seq pc"}, next_pc_o, pc + 32'd4);
        chk({tag, " R7 armed"}, 32'(dly_state_o), 32'd1);
        chk({tag, " R6 link we"}, 32'(link_we_o), 32'(we));
        if (we) begin
            chk({tag, " R3 link idx"}, 32'(link_idx_o), 32'(idx));
            chk({tag, " R5 link data"}, link_data_o, pc);
        end
        cyc(1'b1, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, pc + 32'd4);
        chk({tag, " R7 target"}, next_pc_o, tgt);
        chk({tag, " R7 taken"}, 32'(taken_o), 32'd1);
        chk({tag, " R7 idle"}, 32'(dly_state_o), 32'd0);
        chk({tag, " R7 no link"}, 32'(link_we_o), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pcs [3];
        logic [29:0] flds [6];
        logic [31:0] t;
        pcs[0] = 32'h0000_1000; pcs[1] = 32'hFFFF_FFF0; pcs[2] = 32'h8000_0004;
        flds[0] = 30'h0; flds[1] = 30'h1; flds[2] = 30'h1FFF_FFFF;
        flds[3] = 30'h2000_0000; flds[4] = 30'h3FFF_FFFF; flds[5] = 30'h2A5A_F00F;

        rst_n = 1'b0;
        cyc(1'b0, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0);
        cyc(1'b0, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0);
        // R1 reset state
        chk("R1 next_pc", next_pc_o, 32'h0);
        chk("R1 state", 32'(dly_state_o), 32'd0);
        chk("R1 pulses", {29'd0, link_we_o, taken_o, overlap_err_o}, 32'd0);
        rst_n = 1'b1;

        // R2 sequential retirement
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, pcs[i]);
            chk("R2 fall-through", next_pc_o, pcs[i] + 32'd4);
            chk("R2 idle", 32'(dly_state_o), 32'd0);
        end

        // Sweep of transfer kinds over pcs and fields
        for (int p = 0; p < 3; p++) begin
            for (int j = 0; j < 6; j++) begin
                t = pcs[p] + 32'(sx(32'(flds[j]), 30) * 4);
                xfer("R3 call", 2'b10, flds[j], 32'h0, 32'h0, 1'b0, 5'd0,
                     pcs[p], t, 1'b1, 5'd15);
                t = pcs[p] + 32'(sx(32'(flds[j]), 22) * 4);
                xfer("R4 branch", 2'b01, flds[j], 32'h0, 32'h0, 1'b0, 5'd3,
                     pcs[p], t, 1'b0, 5'd0);
                t = pcs[p] + 32'(sx(32'(flds[j]), 13));
                xfer("R5 jmpl imm", 2'b11, flds[j], pcs[p], 32'hDEAD_0000, 1'b1,
                     5'(j + 1), pcs[p] + 32'h40, t, 1'b1, 5'(j + 1));
                t = pcs[p] + {flds[j], 2'b00};
                xfer("R5 jmpl reg", 2'b11, flds[j], pcs[p], {flds[j], 2'b00}, 1'b0,
                     5'd31, pcs[p] + 32'h80, t, 1'b1, 5'd31);
            end
        end

        // R6 jump with rd = 0: no link write, jump still happens
        xfer("R6 jmpl rd0", 2'b11, 30'h0, 32'h0000_2000, 32'h0000_0010, 1'b0,
             5'd0, 32'h0000_0100, 32'h0000_2010, 1'b0, 5'd0);

        // R10 stalls while armed
        cyc(1'b1, 2'b01, 30'h10, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_3000);
        for (int s = 0; s < 3; s++) begin
            cyc(1'b0, 2'b10, 30'h5, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_9000);
            chk("R10 hold pc", next_pc_o, 32'h0000_3004);
            chk("R10 still armed", 32'(dly_state_o), 32'd1);
            chk("R10 no pulse", {29'd0, link_we_o, taken_o, overlap_err_o}, 32'd0);
        end
        cyc(1'b1, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_3004);
        chk("R10 redirect after stall", next_pc_o, 32'h0000_3040);

        // R8 exception in delay slot
        cyc(1'b1, 2'b10, 30'h100, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_4000);
        cyc(1'b1, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b1, 32'h0000_4004);
        chk("R8 fault state", 32'(dly_state_o), 32'd2);
        chk("R8 no redirect", next_pc_o, 32'h0000_4008);
        chk("R8 no taken", 32'(taken_o), 32'd0);
        cyc(1'b0, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0);
        chk("R8 back idle", 32'(dly_state_o), 32'd0);
        chk("R8 pc kept", next_pc_o, 32'h0000_4008);

        // R9 overlapping request in the delay slot
        cyc(1'b1, 2'b10, 30'h8, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_5000);
        cyc(1'b1, 2'b11, 30'h0, 32'h0000_7000, 32'h0, 1'b1, 5'd9, 1'b0, 32'h0000_5004);
        chk("R9 error pulse", 32'(overlap_err_o), 32'd1);
        chk("R9 no link", 32'(link_we_o), 32'd0);
        chk("R9 original target", next_pc_o, 32'h0000_5020);
        chk("R9 taken", 32'(taken_o), 32'd1);
        cyc(1'b0, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0);
        chk("R9 pulse ends", 32'(overlap_err_o), 32'd0);
        chk("R9 link kept", link_data_o, 32'h0000_5000);

        // R9 request during the fault cycle is rejected
        cyc(1'b1, 2'b01, 30'h4, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_6000);
        cyc(1'b1, 2'b00, 30'h0, 32'h0, 32'h0, 1'b0, 5'd0, 1'b1, 32'h0000_6004);
        cyc(1'b1, 2'b10, 30'h4, 32'h0, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0000_6008);
        chk("R9 fault reject err", 32'(overlap_err_o), 32'd1);
        chk("R9 fault reject idle", 32'(dly_state_o), 32'd0);
        chk("R9 fault reject pc", next_pc_o, 32'h0000_600C);
        chk("R9 fault reject no link", 32'(link_we_o), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule